// File: doc/BRIEF.md
# Conditional Relative Branch Unit

This block resolves the jump instruction class of a 16-bit-word processor. When a two-word jump instruction is presented with a start strobe, the unit tests a 4-bit condition field against the carry, overflow, negative and zero flags. It forms a 32-bit target by adding a signed 24-bit displacement to the address that follows the instruction. It then reports whether the branch is taken and which address execution resumes at. Instruction fetch belongs to the surrounding core. The core supplies the two instruction words, the address of the first word, the flags and the stack pointer.

The subroutine-call variant does not complete straight away. It first raises a store request that carries the stack pointer as the address and the return address as the data. The request is held until the memory side acknowledges it. Only in the cycle after the acknowledge does the unit deliver the new program counter. The stack pointer is not modified here. While a store is outstanding, further start strobes are ignored.

Top module: `branch_unit`

## Requirements
- R1: A start strobe whose first word does not carry 0001 in bits 15..12 is ignored: no done pulse and no store request follow, and taken and next_pc keep their previous values.
- R2: For a jump-class word, condition field bits 11..8 equal to 0000 is always taken. The codes 0001, 0010, 0100 and 1000 are taken when Z, N, O and C, respectively, are set. Done pulses in the cycle after the start edge.
- R3: The condition codes 1110, 1101, 1011 and 0111 are taken when Z, N, O and C, respectively, are clear.
- R4: Every condition code other than 0000, 0001, 0010, 0100, 1000, 1110, 1101, 1011, 0111 and 1111 is never taken.
- R5: The displacement is signed and 24 bits wide, with bits 23..16 from first-word bits 7..0 and bits 15..0 from the second word. A taken branch sets next_pc to insn_addr + 4 + the sign-extended displacement, modulo 2^32.
- R6: A branch that is not taken sets next_pc to insn_addr + 4.
- R7: Code 1111 is a subroutine call. In the cycle after the start edge, st_req rises with st_addr = sp and st_data = insn_addr + 4. These three outputs stay unchanged until st_ack is sampled high, and no done pulse is given meanwhile.
- R8: In the cycle after the edge where st_ack is sampled with st_req high, st_req falls and done pulses with taken = 1 and next_pc = the call target.
- R9: A start strobe that arrives while a store request is outstanding is ignored.
- R10: After reset, done, taken and st_req are 0, and next_pc, st_addr and st_data are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Instruction valid strobe |
| insn_hi | input | 16 | First instruction word (class, condition, displacement high byte) |
| insn_lo | input | 16 | Second instruction word (displacement low 16 bits) |
| flag_c | input | 1 | Carry flag |
| flag_o | input | 1 | Overflow flag |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| insn_addr | input | 32 | Byte address of the first instruction word |
| sp | input | 32 | Stack pointer |
| st_ack | input | 1 | Store acknowledge |
| done | output | 1 | One-cycle result strobe |
| taken | output | 1 | Branch taken, held until the next result |
| next_pc | output | 32 | Resume address, held until the next result |
| st_req | output | 1 | Store request for the return address |
| st_addr | output | 32 | Store address |
| st_data | output | 32 | Store data (return address) |

## Verification
A plain branch produces done, taken and next_pc exactly one cycle after the edge that samples start. A call raises its store request one cycle after that edge, and it completes one cycle after the edge that samples st_ack. Every output is registered, so none depends on the current inputs. The bench's reference model therefore advances on each rising edge using the inputs driven at the previous falling edge. Its predictions are compared with the outputs at every falling edge, which places each check in the cycle where the registered result becomes visible. The stimulus covers every condition code under all-set and all-clear flags, the displacement extremes, foreign-class words, and a start strobe issued while a call waits for its acknowledge.

// File: rtl/branch_unit.sv
module branch_unit #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [15:0]       insn_hi,
  input  logic [15:0]       insn_lo,
  input  logic              flag_c,
  input  logic              flag_o,
  input  logic              flag_n,
  input  logic              flag_z,
  input  logic [ADDR_W-1:0] insn_addr,
  input  logic [ADDR_W-1:0] sp,
  input  logic              st_ack,
  output logic              done,
  output logic              taken,
  output logic [ADDR_W-1:0] next_pc,
  output logic              st_req,
  output logic [ADDR_W-1:0] st_addr,
  output logic [ADDR_W-1:0] st_data
);
  localparam int          OFF_W     = 24;
  localparam logic [3:0]  JUMP_CLS  = 4'b0001;
  localparam logic [3:0]  CC_CALL   = 4'b1111;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  logic [3:0]        cc;
  logic [OFF_W-1:0]  disp;
  logic [ADDR_W-1:0] ret_addr, target, tgt_q;
  logic              is_jump, accept, go;

  assign cc       = insn_hi[11:8];
  assign disp     = {insn_hi[7:0], insn_lo};
  assign ret_addr = insn_addr + STEP;
  assign target   = ret_addr + {{(ADDR_W-OFF_W){disp[OFF_W-1]}}, disp};
  assign is_jump  = insn_hi[15:12] == JUMP_CLS;
  assign accept   = start && is_jump && !st_req;

  always_comb begin
    case (cc)
      4'b0000: go = 1'b1;
      4'b0001: go = flag_z;
      4'b0010: go = flag_n;
      4'b0100: go = flag_o;
      4'b1000: go = flag_c;
      4'b1110: go = !flag_z;
      4'b1101: go = !flag_n;
      4'b1011: go = !flag_o;
      4'b0111: go = !flag_c;
      default: go = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      taken   <= 1'b0;
      next_pc <= '0;
      st_req  <= 1'b0;
      st_addr <= '0;
      st_data <= '0;
      tgt_q   <= '0;
    end else begin
      done <= 1'b0;
      if (st_req) begin
        if (st_ack) begin
          st_req  <= 1'b0;
          done    <= 1'b1;
          taken   <= 1'b1;
          next_pc <= tgt_q;
        end
      end else if (accept) begin
        if (cc == CC_CALL) begin
          st_req  <= 1'b1;
          st_addr <= sp;
          st_data <= ret_addr;
          tgt_q   <= target;
        end else begin
          done    <= 1'b1;
          taken   <= go;
          next_pc <= go ? target : ret_addr;
        end
      end
    end
  end
endmodule

// File: rtl/branch_unit_chk.sv
module branch_unit_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [15:0]       insn_hi,
  input logic              st_ack,
  input logic              done,
  input logic              taken,
  input logic [ADDR_W-1:0] next_pc,
  input logic              st_req,
  input logic [ADDR_W-1:0] st_addr,
  input logic [ADDR_W-1:0] st_data
);
  a_r1_foreign_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !st_req && insn_hi[15:12] != 4'b0001) |=> (!done && !st_req && $stable(taken) && $stable(next_pc)));

  a_r2_always_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !st_req && insn_hi[15:8] == 8'h10) |=> (done && taken));

  a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (st_req && !st_ack) |=> (st_req && !done && $stable(st_addr) && $stable(st_data)));

  a_r8_call_completes: assert property (@(posedge clk) disable iff (!rst_n)
    (st_req && st_ack) |=> (done && taken && !st_req));

  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (st_req && !st_ack && start) |=> st_req);
endmodule

bind branch_unit branch_unit_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/branch_unit_test.sv
module branch_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start = 1'b0;
  logic [15:0] insn_hi = '0, insn_lo = '0;
  logic        flag_c = 0, flag_o = 0, flag_n = 0, flag_z = 0;
  logic [31:0] insn_addr = '0, sp = '0;
  logic        st_ack = 1'b0;
  logic        done, taken, st_req;
  logic [31:0] next_pc, st_addr, st_data;

  branch_unit #(.ADDR_W(32)) uut (.*);

  always #2.5 clk = ~clk;

  int errors = 0, checks = 0, cycles = 0;
  string cur_req = "R10";

  bit          m_done = 0, m_taken = 0, m_req = 0;
  logic [31:0] m_npc = 0, m_addr = 0, m_data = 0, m_tgt = 0;

  function automatic bit cond_true(input logic [3:0] c, input bit fc, fo, fn, fz);
    if (c == 4'h0) return 1;
    if (c == 4'h1) return fz;
    if (c == 4'h2) return fn;
    if (c == 4'h4) return fo;
    if (c == 4'h8) return fc;
    if (c == 4'hE) return !fz;
    if (c == 4'hD) return !fn;
    if (c == 4'hB) return !fo;
    if (c == 4'h7) return !fc;
    return 0;
  endfunction

  always @(posedge clk) begin
    logic [31:0] ret, tgt;
    integer d;
    if (!rst_n) begin
      m_done = 0; m_taken = 0; m_req = 0; m_npc = 0; m_addr = 0; m_data = 0;
    end else if (m_req) begin
      m_done = 0;
      if (st_ack) begin
        m_req = 0; m_done = 1; m_taken = 1; m_npc = m_tgt;
      end
    end else begin
      m_done = 0;
      if (start && insn_hi[15:12] == 4'd1) begin
        d   = {{8{insn_hi[7]}}, insn_hi[7:0], insn_lo};
        ret = insn_addr + 32'd4;
        tgt = ret + d;
        if (insn_hi[11:8] == 4'hF) begin
          m_req = 1; m_addr = sp; m_data = ret; m_tgt = tgt;
        end else begin
          m_done  = 1;
          m_taken = cond_true(insn_hi[11:8], flag_c, flag_o, flag_n, flag_z);
          m_npc   = m_taken ? tgt : ret;
        end
      end
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    chk("done", 32'(done), 32'(m_done));
    chk("taken", 32'(taken), 32'(m_taken));
    chk("next_pc", next_pc, m_npc);
    chk("st_req", 32'(st_req), 32'(m_req));
    if (m_req) begin
      chk("st_addr", st_addr, m_addr);
      chk("st_data", st_data, m_data);
    end
  end

  task automatic issue(input string tag, input logic [15:0] hi, input logic [15:0] lo,
                       input logic [3:0] f, input logic [31:0] a);
    @(negedge clk);
    cur_req = tag;
    insn_hi = hi; insn_lo = lo; {flag_c, flag_o, flag_n, flag_z} = f; insn_addr = a;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    // R10 reset values checked on the cycles above
    // R2 set-flag codes, R3 clear-flag codes, R4 unlisted codes
    for (int c = 0; c < 15; c++) begin
      for (int fp = 0; fp < 4; fp++) begin
        logic [3:0] f;
        string tag;
        f = (fp == 0) ? 4'h0 : (fp == 1) ? 4'hF : (fp == 2) ? 4'hA : 4'h5;
        if (c inside {0, 1, 2, 4, 8}) tag = "R2";
        else if (c inside {14, 13, 11, 7}) tag = "R3";
        else tag = "R4";
        issue(tag, {4'b0001, 4'(c), 8'h01}, 16'h2340, f, 32'h0000_1000 + 32'(c * 64));
      end
    end
    idle(1);
    // R5 displacement extremes and wraparound
    issue("R5", 16'h107F, 16'hFFFF, 4'h0, 32'h1000_0000);
    issue("R5", 16'h1080, 16'h0000, 4'h0, 32'h1000_0000);
    issue("R5", 16'h10FF, 16'hFFFC, 4'h0, 32'h0000_0000);
    issue("R5", 16'h1000, 16'h0010, 4'h0, 32'hFFFF_FFF0);
    // R6 fall-through
    issue("R6", 16'h11AA, 16'h5555, 4'h0, 32'h0000_2220);
    // R1 foreign class words ignored
    issue("R1", 16'h2010, 16'h0001, 4'hF, 32'h0000_3000);
    idle(1);
    issue("R1", 16'h0010, 16'h0001, 4'hF, 32'h0000_3000);
    idle(1);
    issue("R1", 16'h9F00, 16'hFFFF, 4'h0, 32'h0000_3000);
    idle(2);
    // R7 call waits, R9 start during wait ignored, R8 completion
    sp = 32'h00FF_0000;
    issue("R7", 16'h1FFF, 16'hFF00, 4'h0, 32'h0040_0000);
    sp = 32'h1234_5678;
    idle(2);
    cur_req = "R9";
    issue("R9", 16'h1000, 16'h0100, 4'h0, 32'h0000_8000);
    idle(1);
    cur_req = "R8";
    st_ack = 1'b1;
    @(negedge clk);
    st_ack = 1'b0;
    idle(2);
    // R8 acknowledge already high when request rises
    st_ack = 1'b1;
    issue("R8", 16'h1F01, 16'h0000, 4'hF, 32'h0001_0000);
    st_ack = 1'b0;
    idle(2);
    // R10 reset mid-call
    issue("R7", 16'h1F00, 16'h0004, 4'h0, 32'h0000_0100);
    cur_req = "R10";
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule